// File: doc/BRIEF.md
# Gamepad Button Serializer

This block is the logic inside a handheld gamepad. It captures the live button inputs and hands them to a host over a three-wire link: a latch line in, a shift clock in and a single data line out. While the latch line is high, the internal register keeps reloading from the buttons. Once the latch line falls, each rising edge of the shift clock moves the next button onto the data line. When every button has been shifted out, the data line reads 1 for as long as the host keeps clocking.

The register is built from 8-bit stages that are chained through their serial inputs. The last stage's serial input is tied low, and the data output is inverted, so a pressed button reads as 1. The parameter `WIDE` selects a 16-bit report made from two chained stages. The parameter `REDUCED` forces the select and start positions to 0. The latch and clock lines come from outside the block's clock domain, so both are synchronized before their edges are detected.

Top module: `gp_serializer`

## Requirements
- R1: While the synchronized latch is high, the register reloads every block clock cycle, and `data_o` shows report position 0 (`btn_i[0]`), following it live.
- R2: With the latch low, each rising edge of `sclk_i` advances `data_o` by exactly one report position; with no edge, `data_o` holds.
- R3: In 8-bit mode, report position k is `btn_i[k]`: 0 A, 1 B, 2 Select, 3 Start, 4 Up, 5 Down, 6 Left, 7 Right. A pressed (1) input reads as 1.
- R4: After all report positions have been shifted out (8, or 16 when WIDE=1), every further read returns 1.
- R5: With REDUCED=1, positions 2 and 3 always read 0, and all other positions are unchanged.
- R6: With WIDE=1, position k<12 is `btn_i[k]` (B, Y, Select, Start, Up, Down, Left, Right, A, X, L, R), and positions 12 to 15 read 0.
- R7: A rising `sclk_i` edge while the latch is high causes no shift.
- R8: Button changes after the latch has fallen do not alter the bits still to be read.
- R9: After reset and before the first latch, `data_o` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| latch_i | input | 1 | Latch line from the host (asynchronous) |
| sclk_i | input | 1 | Shift clock from the host (asynchronous) |
| btn_i | input | BTN_W (8, or 12 when WIDE=1) | Button states, active high |
| data_o | output | 1 | Serial data, pressed reads 1 |

## Verification
Three instances run side by side: 8-bit full, 8-bit reduced and 16-bit. Random button patterns are read through every report position and four positions beyond. A random pattern separates the positions, so a swapped order or an off-by-one shift shows up. All-ones and all-zeros patterns expose a stuck fill or a missing inversion, because the trailing 1s must differ from the last data bit. Directed cases toggle the buttons during and after the latch, and clock while the latch is high, to separate a live reload from a frozen capture and to check the latch priority.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int STAGE_W     = 8;
  localparam int NARROW_BTNS = 8;
  localparam int WIDE_BTNS   = 12;
  localparam int SYNC_STAGES = 2;
  localparam int IDX_SELECT  = 2;
  localparam int IDX_START   = 3;
endpackage

// File: rtl/gp_sync.sv
module gp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/gp_report_map.sv
module gp_report_map #(
  parameter int WIDE    = 0,
  parameter int REDUCED = 0,
  parameter int BTN_W   = 8,
  parameter int RPT_W   = 8
) (
  input  logic [BTN_W-1:0] btn_i,
  output logic [RPT_W-1:0] rpt_o
);
  always_comb begin
    rpt_o = '0;
    rpt_o[BTN_W-1:0] = btn_i;
    if (REDUCED != 0) begin
      rpt_o[gp_pkg::IDX_SELECT] = 1'b0;
      rpt_o[gp_pkg::IDX_START]  = 1'b0;
    end
  end
endmodule

// File: rtl/gp_stage.sv
module gp_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] par_i,
  input  logic         ser_i,
  output logic         ser_o
);
  logic [W-1:0] q;

  // reset to empty: all zeros reads as 1 after the output inverter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (load_i)  q <= par_i;
    else if (shift_i) q <= {ser_i, q[W-1:1]};
  end

  assign ser_o = q[0];
endmodule

// File: rtl/gp_serializer.sv
module gp_serializer #(
  parameter int WIDE    = 0,
  parameter int REDUCED = 0,
  localparam int BTN_W  = (WIDE != 0) ? gp_pkg::WIDE_BTNS : gp_pkg::NARROW_BTNS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latch_i,
  input  logic             sclk_i,
  input  logic [BTN_W-1:0] btn_i,
  output logic             data_o
);
  localparam int N_STAGES = (WIDE != 0) ? 2 : 1;
  localparam int RPT_W    = N_STAGES * gp_pkg::STAGE_W;

  logic latch_s, sclk_s, sclk_d, sclk_rise;
  logic [RPT_W-1:0] rpt;
  logic [N_STAGES:0] chain;

  gp_sync #(.STAGES(gp_pkg::SYNC_STAGES)) u_sync_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(latch_i), .q_o(latch_s));

  gp_sync #(.STAGES(gp_pkg::SYNC_STAGES)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d;

  gp_report_map #(.WIDE(WIDE), .REDUCED(REDUCED), .BTN_W(BTN_W), .RPT_W(RPT_W)) u_map (
    .btn_i(btn_i), .rpt_o(rpt));

  // tail of chain tied low
  assign chain[N_STAGES] = 1'b0;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    gp_stage #(.W(gp_pkg::STAGE_W)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (latch_s),
      .shift_i(sclk_rise),
      .par_i  (~rpt[s*gp_pkg::STAGE_W +: gp_pkg::STAGE_W]),
      .ser_i  (chain[s+1]),
      .ser_o  (chain[s])
    );
  end

  assign data_o = ~chain[0];
endmodule

// File: rtl/gp_serializer_chk.sv
module gp_serializer_chk #(
  parameter int WIDE    = 0,
  parameter int REDUCED = 0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic latch_s,
  input logic sclk_rise,
  input logic btn0,
  input logic data_o
);
  localparam int RPT_W = (WIDE != 0) ? 16 : 8;

  logic [4:0] shift_cnt;
  logic       loaded;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_cnt <= '0;
      loaded    <= 1'b0;
    end else if (latch_s) begin
      shift_cnt <= '0;
      loaded    <= 1'b1;
    end else if (sclk_rise && shift_cnt != 5'(RPT_W)) begin
      shift_cnt <= shift_cnt + 5'd1;
    end
  end

  // R1 R7
  reload_first_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(latch_s) |-> data_o == $past(btn0));

  // R2
  hold_without_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latch_s && !sclk_rise) |=> $stable(data_o));

  // R4 R9
  fill_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_cnt == 5'(RPT_W) || !loaded) |-> data_o);

  // R5
  reduced_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (REDUCED != 0 && loaded && !latch_s && (shift_cnt == 5'd2 || shift_cnt == 5'd3)) |-> !data_o);

  // R6
  wide_pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WIDE != 0 && loaded && !latch_s && shift_cnt >= 5'd12 && shift_cnt <= 5'd15) |-> !data_o);
endmodule

bind gp_serializer gp_serializer_chk #(.WIDE(WIDE), .REDUCED(REDUCED)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .latch_s(latch_s), .sclk_rise(sclk_rise),
  .btn0(btn_i[0]), .data_o(data_o));

// File: tb/gp_serializer_tb_top.sv
module gp_serializer_tb_top;
  localparam int GAP    = 6;
  localparam int EXTRA  = 4;
  localparam int NPAT   = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic latch = 1'b0;
  logic sclk = 1'b0;
  logic [7:0]  b_n = '0;
  logic [7:0]  b_r = '0;
  logic [11:0] b_w = '0;
  logic d_n, d_r, d_w;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gp_serializer #(.WIDE(0), .REDUCED(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .latch_i(latch), .sclk_i(sclk), .btn_i(b_n), .data_o(d_n));
  gp_serializer #(.WIDE(0), .REDUCED(1)) dut_r_i (
    .clk_i(clk), .rst_ni(rst_n), .latch_i(latch), .sclk_i(sclk), .btn_i(b_r), .data_o(d_r));
  gp_serializer #(.WIDE(1), .REDUCED(0)) dut_w_i (
    .clk_i(clk), .rst_ni(rst_n), .latch_i(latch), .sclk_i(sclk), .btn_i(b_w), .data_o(d_w));

  function automatic logic exp_narrow(logic [7:0] b, bit red, int k);
    if (k >= 8) return 1'b1;
    if (red && (k == 2 || k == 3)) return 1'b0;
    return b[k];
  endfunction

  function automatic logic exp_wide(logic [11:0] b, int k);
    if (k < 12) return b[k];
    if (k < 16) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_gap();
    repeat (GAP) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_sclk();
    sclk = 1'b1; wait_gap();
    sclk = 1'b0; wait_gap();
  endtask

  task automatic latch_pulse();
    latch = 1'b1; wait_gap();
    latch = 1'b0; wait_gap();
  endtask

  task automatic read_all(string tag);
    for (int k = 0; k < 16 + EXTRA; k++) begin
      if (k < 8) check({tag, " R3 R2"}, d_n, exp_narrow(b_n, 1'b0, k));
      else       check({tag, " R4"},    d_n, 1'b1);
      check({tag, " R5"}, d_r, exp_narrow(b_r, 1'b1, k));
      if (k < 16) check({tag, " R6"}, d_w, exp_wide(b_w, k));
      else        check({tag, " R4 wide"}, d_w, 1'b1);
      pulse_sclk();
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset", d_n, 1'b1);
    rst_n = 1'b1;
    wait_gap();
    check("R9 idle n", d_n, 1'b1);
    check("R9 idle w", d_w, 1'b1);

    // directed: all ones, all zeros, walking one
    b_n = 8'hFF; b_r = 8'hFF; b_w = 12'hFFF; latch_pulse(); read_all("ones");
    b_n = 8'h00; b_r = 8'h00; b_w = 12'h000; latch_pulse(); read_all("zeros");
    b_n = 8'h80; b_r = 8'h0C; b_w = 12'h800; latch_pulse(); read_all("edge");

    // R1: live follow while latched; R7: clocking while latched does not shift
    latch = 1'b1;
    b_n = 8'h01; b_w = 12'h001; wait_gap();
    check("R1 live hi", d_n, 1'b1);
    b_n = 8'h00; b_w = 12'h000; wait_gap();
    check("R1 live lo", d_n, 1'b0);
    check("R1 live lo w", d_w, 1'b0);
    b_n = 8'h02;
    pulse_sclk(); pulse_sclk();
    check("R7 no shift", d_n, 1'b0);
    latch = 1'b0; wait_gap();
    check("R7 pos0", d_n, 1'b0);
    // R8: change buttons after latch fell
    b_n = 8'hFD;
    pulse_sclk();
    check("R8 pos1", d_n, 1'b1);
    pulse_sclk();
    check("R8 pos2", d_n, 1'b0);

    // R2: no edge, no change
    b_n = 8'h55; latch_pulse();
    repeat (4) wait_gap();
    check("R2 hold", d_n, 1'b1);
    pulse_sclk();
    check("R2 step", d_n, 1'b0);

    for (int p = 0; p < NPAT; p++) begin
      b_n = 8'($urandom); b_r = 8'($urandom); b_w = 12'($urandom);
      latch_pulse();
      read_all("rand");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule